// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block keeps the interrupt state of a network controller: an 8-bit status register and an 8-bit enable mask. It drives one active-high interrupt request. One-cycle event pulses from the rest of the controller set status bits, and the bits stay set until software clears them. A host write port loads the mask. A second host write port takes an acknowledge byte that clears chosen status bits. Both registers are visible on output ports for the host read path.

Two status bits follow queue state, which is supplied from outside. The transmit-idle bit (bit 2) is raised in every cycle that the transmit queue is empty. The transmit-complete bit (bit 1) is raised in every cycle that the completion queue holds an entry. An acknowledge that selects bit 1 also sends a one-cycle pop request to the completion queue, so each acknowledge consumes one completion entry. Only bits 1, 2, 4, 6 and 7 (the acknowledge byte ANDed with 0xD6) respond to an acknowledge. Bits 0, 3 and 5 cannot be cleared this way.

Bit meanings:

| Bit | Meaning |
|-----|---------|
| 7 | PHY management event |
| 6 | early receive |
| 5 | link event |
| 4 | receive overrun |
| 3 | allocation done |
| 2 | transmit idle |
| 1 | transmit complete |
| 0 | frame received |

Top module: `nic_irq_status`

## Requirements
- R1: After reset, `status_o` is 0x04, `mask_o` is 0x00 and `irq_o` is 0.
- R2: An `evt_set_i` bit that is high at a clock edge makes the matching `status_o` bit 1 from the next cycle on. The bit then holds until an acknowledge clears it.
- R3: An acknowledge write clears exactly the status bits selected by `ack_wdata_i & 0xD6`. Bits 0, 3 and 5 and all unselected bits keep their value.
- R4: If an event bit and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R5: While `txq_empty_i` is high, status bit 2 is set in the next cycle, and an acknowledge in that cycle cannot clear it.
- R6: While `cmplq_nonempty_i` is high, status bit 1 is set in the next cycle, and an acknowledge in that cycle cannot clear it.
- R7: `cmplq_pop_o` is high, combinationally, in exactly the cycles that carry an acknowledge write with bit 1 set.
- R8: A mask write makes `mask_o` equal to the written byte from the next cycle on. Without a write, the mask holds.
- R9: `irq_o` equals the OR of (`status_o` AND `mask_o`) as it stood one cycle earlier.
- R10: A status bit never clears without an acknowledge that selects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| evt_set_i | input | 8 | event pulses, one per status bit |
| txq_empty_i | input | 1 | transmit queue holds no entry |
| cmplq_nonempty_i | input | 1 | completion queue holds at least one entry |
| mask_we_i | input | 1 | mask write strobe |
| mask_wdata_i | input | 8 | new mask value |
| ack_we_i | input | 1 | acknowledge write strobe |
| ack_wdata_i | input | 8 | acknowledge byte, 1 = clear this bit |
| status_o | output | 8 | current status register |
| mask_o | output | 8 | current mask register |
| cmplq_pop_o | output | 1 | pop request to the completion queue |
| irq_o | output | 1 | registered interrupt request |

## Verification
The assertions assume that the event, queue-state and write inputs are stable around the clock edge. They also assume these inputs carry defined values once reset is released. They make no assumption about how often the inputs change.

The bench drives every input on the falling edge. After the internal reset release, it keeps the inputs idle for the synchronizer latency. Random traffic uses sparse event vectors, so that acknowledges regularly meet bits that are already set. The queue-state inputs are allowed to toggle freely, because the design must tolerate any pattern on them.

// File: rtl/nic_irq_status_pkg.sv
package nic_irq_status_pkg;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned BIT_TX_IDLE  = 2;
  localparam int unsigned BIT_TX_CMPL  = 1;
  localparam logic [STAT_W-1:0] ACK_CLR_MASK = 8'hD6;
  localparam logic [STAT_W-1:0] STAT_RST_VAL = 8'h04;
  typedef logic [STAT_W-1:0] stat_vec_t;
endpackage

// File: rtl/nic_irq_rst_sync.sv
module nic_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/nic_irq_stat_bank.sv
module nic_irq_stat_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] CLR_MASK = '1,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] clr_vec;

  always_comb begin
    clr_vec = {W{ack_we_i}} & ack_i & CLR_MASK;
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic bit_d, bit_q, bit_en;

    always_comb begin
      bit_d  = bit_q;
      bit_en = clr_vec[gi] | set_i[gi];
      if (clr_vec[gi]) bit_d = 1'b0;
      if (set_i[gi])   bit_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= RST_VAL[gi];
      else if (bit_en) bit_q <= bit_d;
    end

    assign stat_o[gi] = bit_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[gi] |=> bit_q); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[gi] && ack_we_i && ack_i[gi]) |=> bit_q); // R4

    if (CLR_MASK[gi]) begin : g_clr
      AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !(ack_we_i && ack_i[gi])) |=> bit_q); // R10
    end else begin : g_lock
      AST_LOCKED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q |=> bit_q); // R3
    end
  end
endmodule

// File: rtl/nic_irq_mask_reg.sv
module nic_irq_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_d, mask_q;

  always_comb begin
    mask_d = mask_q;
    if (we_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i))); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q)); // R8
endmodule

// File: rtl/nic_irq_line.sv
module nic_irq_line #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    irq_d = |(stat_i & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_set_i,
  input  logic       txq_empty_i,
  input  logic       cmplq_nonempty_i,
  input  logic       mask_we_i,
  input  logic [7:0] mask_wdata_i,
  input  logic       ack_we_i,
  input  logic [7:0] ack_wdata_i,
  output logic [7:0] status_o,
  output logic [7:0] mask_o,
  output logic       cmplq_pop_o,
  output logic       irq_o
);
  logic      rst_n_s;
  stat_vec_t set_vec;

  nic_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    set_vec              = evt_set_i;
    set_vec[BIT_TX_IDLE] = evt_set_i[BIT_TX_IDLE] | txq_empty_i;
    set_vec[BIT_TX_CMPL] = evt_set_i[BIT_TX_CMPL] | cmplq_nonempty_i;
  end

  nic_irq_stat_bank #(.W(STAT_W), .CLR_MASK(ACK_CLR_MASK), .RST_VAL(STAT_RST_VAL)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .set_i(set_vec),
    .ack_we_i(ack_we_i), .ack_i(ack_wdata_i), .stat_o(status_o)
  );

  nic_irq_mask_reg #(.W(STAT_W)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .we_i(mask_we_i),
    .wdata_i(mask_wdata_i), .mask_o(mask_o)
  );

  nic_irq_line #(.W(STAT_W)) u_line (
    .clk(clk), .rst_n(rst_n_s), .stat_i(status_o),
    .mask_i(mask_o), .irq_o(irq_o)
  );

  assign cmplq_pop_o = ack_we_i & ack_wdata_i[BIT_TX_CMPL];

  AST_TX_IDLE_FORCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    txq_empty_i |=> status_o[BIT_TX_IDLE]); // R5
  AST_TX_CMPL_FORCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmplq_nonempty_i |=> status_o[BIT_TX_CMPL]); // R6
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmplq_pop_o && !cmplq_nonempty_i && !evt_set_i[BIT_TX_CMPL]) |=> !status_o[BIT_TX_CMPL]); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|(status_o & mask_o)) |=> irq_o); // R9
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(|(status_o & mask_o)) |=> !irq_o); // R9
endmodule

// File: tb/sim_nic_irq_status.sv
`timescale 1ns/1ps
module sim_nic_irq_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt, mwd, awd;
  logic       txe, dne, mwe, awe;
  logic [7:0] status_o, mask_o;
  logic       pop_o, irq_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] e_stat, e_mask;
  logic       e_irq;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  nic_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt), .txq_empty_i(txe),
    .cmplq_nonempty_i(dne), .mask_we_i(mwe), .mask_wdata_i(mwd),
    .ack_we_i(awe), .ack_wdata_i(awd), .status_o(status_o),
    .mask_o(mask_o), .cmplq_pop_o(pop_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] next_stat(logic [7:0] s, logic [7:0] e,
      logic te, logic de, logic we, logic [7:0] a);
    logic [7:0] clr;
    clr = we ? (a & 8'hD6) : 8'h00;
    return (s & ~clr) | e | {5'b0, te, de, 1'b0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [7:0] e, logic te, logic de, logic mw, logic [7:0] md,
      logic aw, logic [7:0] ad, string tag);
    logic [7:0] ns;
    @(negedge clk);
    evt = e; txe = te; dne = de; mwe = mw; mwd = md; awe = aw; awd = ad;
    #1;
    chk("R7 pop", {7'b0, pop_o}, {7'b0, aw & ad[1]});
    ns     = next_stat(e_stat, e, te, de, aw, ad);
    e_irq  = |(e_stat & e_mask);
    e_stat = ns;
    if (mw) e_mask = md;
    @(posedge clk); #1;
    chk({tag, " status"}, status_o, e_stat);
    chk("R8 mask", mask_o, e_mask);
    chk("R9 irq", {7'b0, irq_o}, {7'b0, e_irq});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0; evt = '0; txe = 0; dne = 0; mwe = 0; mwd = '0; awe = 0; awd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    e_stat = 8'h04; e_mask = 8'h00; e_irq = 1'b0;
    chk("R1 status", status_o, 8'h04);
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2: set everything, then R3: ack all, locked bits survive
    step(8'hFF, 0, 0, 0, 8'h00, 0, 8'h00, "R2");
    step(8'h00, 0, 0, 0, 8'h00, 1, 8'hFF, "R3");
    chk("R3 locked bits", status_o, 8'h29);
    // R4: set and ack same bit together
    step(8'h40, 0, 0, 0, 8'h00, 1, 8'h40, "R4");
    chk("R4 set wins", status_o & 8'h40, 8'h40);
    // R5: idle queue defeats ack of bit 2
    step(8'h00, 1, 0, 0, 8'h00, 1, 8'h04, "R5");
    chk("R5 bit2", status_o & 8'h04, 8'h04);
    // R6/R7: completion nonempty defeats ack of bit 1, pop issued
    step(8'h00, 0, 1, 0, 8'h00, 1, 8'h02, "R6");
    chk("R6 bit1", status_o & 8'h02, 8'h02);
    step(8'h00, 0, 0, 0, 8'h00, 1, 8'h02, "R7");
    chk("R7 bit1 cleared", status_o & 8'h02, 8'h00);
    // R8/R9: mask write, irq one cycle later
    step(8'h00, 0, 0, 1, 8'h01, 0, 8'h00, "R8");
    chk("R9 irq lags mask", {7'b0, irq_o}, 8'h00);
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'h00, "R9");
    chk("R9 irq up", {7'b0, irq_o}, 8'h01);

    // random traffic, R10 covered by the per-cycle model check
    for (int i = 0; i < 400; i++) begin
      step($urandom & $urandom & $urandom, $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 3) == 0), $urandom, ($urandom_range(0, 2) == 0),
           $urandom, "R10 random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule